// File: doc/BRIEF.md
# Host Controller Interrupt Status Unit

This block gathers single-cycle event pulses into one sticky status register. The pulses come from a card host controller's command engine, data path, FIFO logic and card-detect logic. Software reads and clears that register through a small register port. A per-bit enable mask and one global enable bit decide whether pending events drive the single interrupt line.

Software can always read the unmasked (raw) view. It can therefore poll error events that it chooses not to take as interrupts. The gated view is the raw status ANDed with the mask, and it has its own read-only offset. Bits are cleared by writing ones to the raw view. Writing all ones acknowledges everything that is pending.

Top module: `hc_irq_status`

## Requirements
- R1: After reset, the raw status, mask and global enable are all zero, `irq_o` is 0, and a read of any offset returns 0.
- R2: A 1 on `evt_i[n]` in a cycle sets raw status bit n at that clock edge, and the bit stays set until software clears it. The bit layout is fixed: 0 card detect, 1 response error, 2 command done, 3 data transfer over, 4 TX data request, 5 RX data request, 6 response CRC, 7 data CRC, 8 response timeout, 9 data read timeout, 10 starvation timeout, 11 FIFO over/underrun, 12 hardware-locked error, 13 start-bit error, 14 auto-command done, 15 end-bit error, and 19:16 SDIO.
- R3: A write to offset 2 (raw status) clears exactly the bits written as 1. Writing all ones clears every pending bit.
- R4: If an event pulse and a write-1-to-clear of the same bit fall in the same cycle, the bit stays set.
- R5: A read of offset 3 returns raw status ANDed with the mask register (offset 1).
- R6: A read of offset 2 returns every pending bit, whatever the mask holds.
- R7: `irq_o` is 1 exactly when control bit 4 (global enable, offset 0) is 1 and at least one masked status bit is 1. It follows the register state with one cycle of latency.
- R8: Writing 0 bits to offset 2 leaves those bits unchanged. Any write to offset 3 has no effect on status.
- R9: The control register keeps only bit 4. Its other bits always read 0.
- R10: A read issued with `rd_en_i` returns its data on `rd_data_o` one cycle later, with `rd_vld_o` high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 20 | Event pulses, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register offset: 0 control, 1 mask, 2 raw status, 3 masked status |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| rd_vld_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt line |

## Verification
Assertions check on every cycle that a raw bit rises only after an event, and that no pulse is lost. They also check that a bit falls only when its clear was requested with no competing event, and that the interrupt stays low while the global enable is off or nothing masked is pending. The bench scenarios are what show the register map behaviour from outside: the reset readback, the control bits that are dropped, the masked and raw views under different masks, writes of zero bits and writes to the read-only offset, the event-versus-clear collision, and the SDIO nibble.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    OFS_CTRL   = 2'd0,
    OFS_MASK   = 2'd1,
    OFS_RAW    = 2'd2,
    OFS_MASKED = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/hc_irq_bank.sv
module hc_irq_bank #(
  parameter int EVT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] clr_i,
  output logic [EVT_W-1:0] raw_o
);
  logic [EVT_W-1:0] raw_q;

  for (genvar b = 0; b < EVT_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           raw_q[b] <= 1'b0;
      else if (evt_i[b]) raw_q[b] <= 1'b1;
      else if (clr_i[b]) raw_q[b] <= 1'b0;
    end
  end

  assign raw_o = raw_q;

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(evt_i)) == '0)); // R2
  AST_EVENT_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(evt_i) & ~raw_q) == '0)); // R4
  AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(raw_q) & ~$past(clr_i) & ~raw_q) == '0)); // R2
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(clr_i) & ~$past(evt_i) & raw_q) == '0)); // R3
endmodule

// File: rtl/hc_irq_cfg.sv
module hc_irq_cfg #(
  parameter int EVT_W  = 20,
  parameter int DATA_W = 32,
  parameter int EN_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl_i,
  input  logic              wr_mask_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output logic [EVT_W-1:0]  mask_o
);
  logic             en_q;
  logic [EVT_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl_i) en_q   <= wdata_i[EN_BIT];
      if (wr_mask_i) mask_q <= wdata_i[EVT_W-1:0];
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_mask_i |=> $stable(mask_q)); // R5
endmodule

// File: rtl/hc_irq_rdmux.sv
module hc_irq_rdmux
  import hc_irq_pkg::*;
#(
  parameter int EVT_W  = 20,
  parameter int DATA_W = 32,
  parameter int EN_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic [EVT_W-1:0]  mask_i,
  input  logic [EVT_W-1:0]  raw_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o
);
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] rd_q;
  logic              vld_q;

  always_comb begin
    sel = '0;
    unique case (reg_ofs_e'(addr_i))
      OFS_CTRL:   sel[EN_BIT] = en_i;
      OFS_MASK:   sel = DATA_W'(mask_i);
      OFS_RAW:    sel = DATA_W'(raw_i);
      OFS_MASKED: sel = DATA_W'(raw_i & mask_i);
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_en_i;
      if (rd_en_i) rd_q <= sel;
    end
  end

  assign rd_data_o = rd_q;
  assign rd_vld_o  = vld_q;

  AST_VLD_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_vld_o); // R10
  AST_VLD_ONLY_ON_RD: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> !rd_vld_o); // R10
endmodule

// File: rtl/hc_irq_status.sv
module hc_irq_status
  import hc_irq_pkg::*;
#(
  parameter int EVT_W  = 20,
  parameter int DATA_W = 32,
  parameter int EN_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);

  logic             wr_ctrl, wr_mask, wr_raw;
  logic [EVT_W-1:0] clr, raw, mask;
  logic             en;
  logic             irq_q;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_mask = wr_en_i && (addr_i == A_MASK);
  assign wr_raw  = wr_en_i && (addr_i == A_RAW);
  assign clr     = wr_raw ? wdata_i[EVT_W-1:0] : '0;

  hc_irq_bank #(.EVT_W(EVT_W)) u_bank (
    .clk(clk), .rst(rst), .evt_i(evt_i), .clr_i(clr), .raw_o(raw)
  );

  hc_irq_cfg #(.EVT_W(EVT_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_cfg (
    .clk(clk), .rst(rst), .wr_ctrl_i(wr_ctrl), .wr_mask_i(wr_mask),
    .wdata_i(wdata_i), .en_o(en), .mask_o(mask)
  );

  hc_irq_rdmux #(.EVT_W(EVT_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_rd (
    .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .en_i(en), .mask_i(mask), .raw_i(raw),
    .rd_data_o(rd_data_o), .rd_vld_o(rd_vld_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= en && ((raw & mask) != '0);
  end

  assign irq_o = irq_q;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq_o); // R7
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    ((raw & mask) == '0) |=> !irq_o); // R7
  AST_IRQ_RAISES: assert property (@(posedge clk) disable iff (rst)
    (en && ((raw & mask) != '0)) |=> irq_o); // R7
endmodule

// File: tb/hc_irq_status_bench.sv
module hc_irq_status_bench;
  localparam int EVT_W  = 20;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [EVT_W-1:0]  evt = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [1:0]        addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_vld;
  logic              irq;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #2 clk = ~clk;

  hc_irq_status u_hc_irq_status (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rd_data_o(rd_data), .rd_vld_o(rd_vld),
    .irq_o(irq)
  );

  // monitor: pops expected read data when the design presents a result
  always @(negedge clk) begin
    if (!rst && rd_vld) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected read data %h, expected none", rd_data);
      end else begin
        logic [DATA_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: read %h, expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input logic [DATA_W-1:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [EVT_W-1:0] p);
    @(negedge clk);
    evt = p;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq %b, expected %b", t, irq, e);
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (irq !== 1'b0 || rd_data !== '0) begin
      errors++;
      $display("FAIL R1: irq %b data %h, expected 0 0", irq, rd_data);
    end
    reg_rd(2'd0, 32'h0, "R1");
    reg_rd(2'd1, 32'h0, "R1");
    reg_rd(2'd2, 32'h0, "R1");
    reg_rd(2'd3, 32'h0, "R1");
    // R2: command-done pulse (bit 2) is captured and held
    pulse(20'h00004);
    reg_rd(2'd2, 32'h4, "R2");
    idle(5);
    reg_rd(2'd2, 32'h4, "R2");
    // R6: raw view visible with mask clear; masked view empty
    reg_rd(2'd3, 32'h0, "R5");
    chk_irq(1'b0, "R7");
    // R9: control keeps only bit 4
    reg_wr(2'd0, 32'hFFFF_FFFF);
    reg_rd(2'd0, 32'h10, "R9");
    chk_irq(1'b0, "R7");
    // R5 / R7: unmask bit 2
    reg_wr(2'd1, 32'h4);
    reg_rd(2'd3, 32'h4, "R5");
    chk_irq(1'b1, "R7");
    reg_wr(2'd0, 32'h0);
    chk_irq(1'b0, "R7");
    // R6: timeout and end-bit errors stay visible while masked
    pulse(20'h08100);
    reg_rd(2'd2, 32'h8104, "R6");
    reg_rd(2'd3, 32'h4, "R5");
    // R8: zero bits and read-only offset leave status alone
    reg_wr(2'd2, 32'h0);
    reg_rd(2'd2, 32'h8104, "R8");
    reg_wr(2'd3, 32'hFFFF_FFFF);
    reg_rd(2'd2, 32'h8104, "R8");
    // R3: clear only bit 2
    reg_wr(2'd2, 32'h4);
    reg_rd(2'd2, 32'h8100, "R3");
    // R4: event and clear of bit 8 in the same cycle
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd2; wdata = 32'h100; evt = 20'h00100;
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
    reg_rd(2'd2, 32'h8100, "R4");
    // R3: clear everything
    reg_wr(2'd2, 32'hFFFF_FFFF);
    reg_rd(2'd2, 32'h0, "R3");
    // SDIO nibble with partial mask, global enable on
    pulse(20'hF0000);
    reg_wr(2'd1, 32'h10000);
    reg_wr(2'd0, 32'h10);
    reg_rd(2'd2, 32'hF0000, "R2");
    reg_rd(2'd3, 32'h10000, "R5");
    chk_irq(1'b1, "R7");
    reg_wr(2'd2, 32'h10000);
    reg_rd(2'd2, 32'hE0000, "R3");
    chk_irq(1'b0, "R7");
    idle(2);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: %0d reads unanswered, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule